// File: doc/BRIEF.md
# Fan Fault Detector with Wake Event

This block watches three cooling fans and reports when any of them is failing. For each fan it receives the measured tachometer period count, the largest count the fan may show, a timeout in ticks, the commanded PWM duty and a one-cycle pulse for each tach edge. A fan is in fault when its period count stays above the allowed count for longer than its timeout. A fan is also in fault when it is being driven with nonzero duty but has produced no tach edge for more than three seconds. Both timers advance on a 1 kHz tick input.

Each fan has a live fault flag, which follows the present condition, and a sticky status flag. The sticky flag records every new fault until software clears it by writing 1 to it. The sticky flags are masked by per-fan enable bits. The masked result drives one active-low wake request to the power-management logic. Software reaches the enable, sticky and live flags through a byte-wide register port at three consecutive indices. Reads are combinational and writes are taken on a one-cycle strobe.

Top module: `fan_fault_wake`

## Requirements
- R1: After reset every enable bit and every sticky status bit is 0, and `pme_n` is 1.
- R2: The enable flags are at index 0x90, the sticky flags at 0x91 and the live flags at 0x92. Fan 1 is bit 0, fan 2 is bit 1 and fan 3 is bit 2. Bits 7:3 always read 0, and any other index reads 0x00.
- R3: A fan is "slow" when its tach count is strictly greater than its count limit. The slow timer starts at 0 and advances by one on each tick while the fan stays slow. The fan's live bit is 1 while the fan is slow and the timer has reached timeout+1. The live bit returns to 0 in the cycle the fan stops being slow.
- R4: Take a fan whose duty is nonzero. When more than `STALL_TICKS` ticks (3000 by default) pass with no tach pulse, its live bit is 1.
- R5: The stall timer restarts from 0 on any cycle with a tach pulse or with duty equal to 0.
- R6: A 0-to-1 change of a live bit sets the matching sticky bit at the next clock edge.
- R7: Writing 1 to a bit at 0x91 clears that sticky bit. Writing 0 leaves the bit unchanged.
- R8: If a sticky bit is set and cleared by a write in the same cycle, the bit ends up set.
- R9: `pme_n` is 0 exactly when some fan has both its enable bit and its sticky bit at 1.
- R10: Writes to 0x92 have no effect on any flag.
- R11: The timers advance only in cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 1 kHz timing strobe, one cycle wide |
| tach_count | input | 48 | Measured period count, 16 bits per fan, fan 1 in bits 15:0 |
| count_limit | input | 48 | Largest allowed count, 16 bits per fan |
| timeout | input | 24 | Slow timeout in ticks, 8 bits per fan |
| duty | input | 24 | Commanded PWM duty, 8 bits per fan |
| tach_pulse | input | 3 | One-cycle pulse per tach edge, one bit per fan |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pme_n | output | 1 | Active-low wake request |

## Verification
The bench measures the timing of each threshold to the exact tick. It checks a timeout of 0 and of 255, and one tick below and one tick at each threshold. An off-by-one compare would flag a fan one tick early or one tick late. It checks that stalls are forgotten after a tach pulse and after duty falls to 0; a missing restart would raise a false stall once the timer has run long enough in total. It writes a clear in the same cycle as a new fault, which catches a design that lets the clear win and loses the event. It also writes to the read-only index and to the reserved bits, which catches a decoder that aliases indices or stores the upper bits.

// File: rtl/fan_mon_pkg.sv
package fan_mon_pkg;
  localparam int NUM_FANS = 3;
  localparam int REG_W    = 8;

  localparam logic [REG_W-1:0] IDX_ENABLE = 8'h90;
  localparam logic [REG_W-1:0] IDX_STICKY = 8'h91;
  localparam logic [REG_W-1:0] IDX_LIVE   = 8'h92;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STICKY = 2'd2,
    SEL_LIVE   = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_idx(input logic [REG_W-1:0] idx);
    case (idx)
      IDX_ENABLE: decode_idx = SEL_ENABLE;
      IDX_STICKY: decode_idx = SEL_STICKY;
      IDX_LIVE:   decode_idx = SEL_LIVE;
      default:    decode_idx = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/fan_chan_timer.sv
module fan_chan_timer #(
  parameter int CNT_W       = 16,
  parameter int TO_W        = 8,
  parameter int DUTY_W      = 8,
  parameter int STALL_TICKS = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  tach_count,
  input  logic [CNT_W-1:0]  count_limit,
  input  logic [TO_W-1:0]   timeout,
  input  logic [DUTY_W-1:0] duty,
  input  logic              tach_pulse,
  output logic              fault
);
  localparam int SLOW_W  = TO_W + 1;
  localparam int STALL_W = $clog2(STALL_TICKS + 2);
  localparam logic [SLOW_W-1:0]  SLOW_ONE  = SLOW_W'(1);
  localparam logic [STALL_W-1:0] STALL_ONE = STALL_W'(1);
  localparam logic [STALL_W-1:0] STALL_LIM = STALL_W'(STALL_TICKS);

  logic [SLOW_W-1:0]  slow_cnt_q, slow_cnt_d;
  logic [STALL_W-1:0] stall_cnt_q, stall_cnt_d;
  logic [SLOW_W-1:0]  tmo_ext;
  logic               slow_now, run_cmd;
  logic               slow_flt, stall_flt;
  logic               slow_en, stall_en;

  assign tmo_ext  = {1'b0, timeout};
  assign slow_now = (tach_count > count_limit);
  assign run_cmd  = (duty != '0);

  // Slow-fan timer: cleared when healthy, saturates at timeout+1
  always_comb begin
    slow_en    = 1'b0;
    slow_cnt_d = slow_cnt_q;
    if (!slow_now) begin
      slow_en    = 1'b1;
      slow_cnt_d = '0;
    end else if (tick && (slow_cnt_q <= tmo_ext)) begin
      slow_en    = 1'b1;
      slow_cnt_d = slow_cnt_q + SLOW_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slow_cnt_q <= '0;
    else if (slow_en)
      slow_cnt_q <= slow_cnt_d;
  end

  // Stall timer: restarted by a tach edge or zero duty, saturates at limit+1
  always_comb begin
    stall_en    = 1'b0;
    stall_cnt_d = stall_cnt_q;
    if (tach_pulse || !run_cmd) begin
      stall_en    = 1'b1;
      stall_cnt_d = '0;
    end else if (tick && (stall_cnt_q <= STALL_LIM)) begin
      stall_en    = 1'b1;
      stall_cnt_d = stall_cnt_q + STALL_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stall_cnt_q <= '0;
    else if (stall_en)
      stall_cnt_q <= stall_cnt_d;
  end

  assign slow_flt  = slow_now && (slow_cnt_q > tmo_ext);
  assign stall_flt = run_cmd && (stall_cnt_q > STALL_LIM);
  assign fault     = slow_flt | stall_flt;
endmodule

// File: rtl/fan_evt_regs.sv
module fan_evt_regs
  import fan_mon_pkg::*;
#(
  parameter int NUM_FANS = fan_mon_pkg::NUM_FANS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FANS-1:0] live,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_FANS-1:0] en_q,
  output logic [NUM_FANS-1:0] sts_q,
  output logic                pme_n
);
  localparam int PAD_W = REG_W - NUM_FANS;

  reg_sel_e            sel;
  logic [NUM_FANS-1:0] en_d, sts_d, live_prev_q;
  logic [NUM_FANS-1:0] set_vec, clr_vec, wbits;
  logic                en_we, sts_we;
  logic                unused_wdata_hi;

  assign sel             = decode_idx(reg_addr);
  assign wbits           = reg_wdata[NUM_FANS-1:0];
  assign unused_wdata_hi = ^reg_wdata[REG_W-1:NUM_FANS];

  assign set_vec = live & ~live_prev_q;
  assign clr_vec = (reg_wr && (sel == SEL_STICKY)) ? wbits : '0;

  always_comb begin
    en_we = reg_wr && (sel == SEL_ENABLE);
    en_d  = en_q;
    if (en_we)
      en_d = wbits;
  end

  always_comb begin
    sts_we = (|set_vec) || (|clr_vec);
    sts_d  = (sts_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '0;
      sts_q       <= '0;
      live_prev_q <= '0;
    end else begin
      if (en_we)
        en_q <= en_d;
      if (sts_we)
        sts_q <= sts_d;
      live_prev_q <= live;
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: reg_rdata = {{PAD_W{1'b0}}, en_q};
      SEL_STICKY: reg_rdata = {{PAD_W{1'b0}}, sts_q};
      SEL_LIVE:   reg_rdata = {{PAD_W{1'b0}}, live};
      default:    reg_rdata = '0;
    endcase
  end

  assign pme_n = ~|(en_q & sts_q);
endmodule

// File: rtl/fan_fault_wake.sv
module fan_fault_wake
  import fan_mon_pkg::*;
#(
  parameter int NUM_FANS    = fan_mon_pkg::NUM_FANS,
  parameter int CNT_W       = 16,
  parameter int TO_W        = 8,
  parameter int DUTY_W      = 8,
  parameter int STALL_TICKS = 3000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic [NUM_FANS*CNT_W-1:0]  tach_count,
  input  logic [NUM_FANS*CNT_W-1:0]  count_limit,
  input  logic [NUM_FANS*TO_W-1:0]   timeout,
  input  logic [NUM_FANS*DUTY_W-1:0] duty,
  input  logic [NUM_FANS-1:0]        tach_pulse,
  input  logic [REG_W-1:0]           reg_addr,
  input  logic                       reg_wr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  output logic                       pme_n
);
  logic [NUM_FANS-1:0] live_vec;
  logic [NUM_FANS-1:0] en_vec;
  logic [NUM_FANS-1:0] sts_vec;

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_chan
    fan_chan_timer #(
      .CNT_W      (CNT_W),
      .TO_W       (TO_W),
      .DUTY_W     (DUTY_W),
      .STALL_TICKS(STALL_TICKS)
    ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .tach_count (tach_count[g*CNT_W +: CNT_W]),
      .count_limit(count_limit[g*CNT_W +: CNT_W]),
      .timeout    (timeout[g*TO_W +: TO_W]),
      .duty       (duty[g*DUTY_W +: DUTY_W]),
      .tach_pulse (tach_pulse[g]),
      .fault      (live_vec[g])
    );
  end

  fan_evt_regs #(
    .NUM_FANS(NUM_FANS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .live     (live_vec),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .en_q     (en_vec),
    .sts_q    (sts_vec),
    .pme_n    (pme_n)
  );
endmodule

// File: rtl/fan_fault_wake_chk.sv
module fan_fault_wake_chk
  import fan_mon_pkg::*;
#(
  parameter int NUM_FANS = fan_mon_pkg::NUM_FANS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [REG_W-1:0]    reg_addr,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [REG_W-1:0]    reg_rdata,
  input logic                pme_n,
  input logic [NUM_FANS-1:0] live_bits,
  input logic [NUM_FANS-1:0] sts_bits,
  input logic [NUM_FANS-1:0] en_bits
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NUM_FANS] == '0);

  // R9
  pme_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> ((en_bits & sts_bits) != '0));

  // R10
  live_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == IDX_LIVE) |=> ($stable(en_bits) && ($past(sts_bits) & ~sts_bits) == '0));

  for (genvar i = 0; i < NUM_FANS; i++) begin : g_fan
    // R6 R8
    rise_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(live_bits[i]) |=> sts_bits[i]);

    // R7
    sts_clear_by_w1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_bits[i]) |-> $past(reg_wr && reg_addr == IDX_STICKY && reg_wdata[i]));
  end
endmodule

bind fan_fault_wake fan_fault_wake_chk #(.NUM_FANS(NUM_FANS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .pme_n    (pme_n),
  .live_bits(live_vec),
  .sts_bits (sts_vec),
  .en_bits  (en_vec)
);

// File: tb/sim_fan_fault_wake.sv
module sim_fan_fault_wake;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [47:0] tach_count, count_limit;
  logic [23:0] timeout, duty;
  logic [2:0]  tach_pulse;
  logic [7:0]  reg_addr, reg_wdata, reg_rdata;
  logic        reg_wr, pme_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fan_fault_wake u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .tach_count(tach_count), .count_limit(count_limit),
    .timeout(timeout), .duty(duty), .tach_pulse(tach_pulse),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pme_n(pme_n)
  );

  typedef struct packed {
    logic [1:0] fan;
    logic [7:0] tmo;
    logic [8:0] run;
    logic       exp;
  } slow_case_t;

  localparam slow_case_t CASES [8] = '{
    '{2'd0, 8'd5,   9'd5,   1'b0},
    '{2'd0, 8'd5,   9'd6,   1'b1},
    '{2'd1, 8'd0,   9'd0,   1'b0},
    '{2'd1, 8'd0,   9'd1,   1'b1},
    '{2'd2, 8'd255, 9'd255, 1'b0},
    '{2'd2, 8'd255, 9'd256, 1'b1},
    '{2'd0, 8'd20,  9'd3,   1'b0},
    '{2'd2, 8'd1,   9'd2,   1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic healthy();
    tach_count  = {3{16'd100}};
    count_limit = {3{16'd200}};
    duty        = '0;
    tach_pulse  = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; tick = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    timeout = '0;
    healthy();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h90, d); chk("R1 enable", d, 8'h00);
    rd(8'h91, d); chk("R1 sticky", d, 8'h00);
    chk("R1 pme_n", {7'd0, pme_n}, 8'h01);

    // R3 slow timeout table
    foreach (CASES[k]) begin
      timeout = {3{CASES[k].tmo}};
      @(negedge clk);
      tach_count[CASES[k].fan*16 +: 16] = 16'd300;
      repeat (int'(CASES[k].run)) @(negedge clk);
      rd(8'h92, d);
      chk("R3 slow timeout", d, 8'(CASES[k].exp) << CASES[k].fan);
      healthy();
      #1;
      rd(8'h92, d); chk("R3 drops when healthy", d, 8'h00);
      @(negedge clk);
      wr(8'h91, 8'h07);
    end

    // R11 timers frozen without tick
    timeout = '0;
    tick = 1'b0;
    tach_count[15:0] = 16'd300;
    repeat (10) @(negedge clk);
    rd(8'h92, d); chk("R11 no tick no advance", d, 8'h00);
    tick = 1'b1;
    @(negedge clk);
    rd(8'h92, d); chk("R11 one tick advances", d, 8'h01);
    healthy();
    @(negedge clk);
    wr(8'h91, 8'h07);

    // R4 stall threshold on fan 2
    duty[15:8] = 8'd50;
    repeat (3000) @(negedge clk);
    rd(8'h92, d); chk("R4 stall at 3000 ticks", d, 8'h00);
    @(negedge clk);
    rd(8'h92, d); chk("R4 stall after 3001 ticks", d, 8'h02);
    @(negedge clk);
    rd(8'h91, d); chk("R6 sticky set by stall", d, 8'h02);

    // R9 wake gating
    wr(8'h90, 8'h02);
    chk("R9 enabled sticky drives pme_n low", {7'd0, pme_n}, 8'h00);
    wr(8'h90, 8'h05);
    chk("R9 masked sticky leaves pme_n high", {7'd0, pme_n}, 8'h01);
    wr(8'h90, 8'h02);

    // R10 write to live index ignored
    wr(8'h92, 8'hFF);
    rd(8'h90, d); chk("R10 enable unchanged", d, 8'h02);
    rd(8'h91, d); chk("R10 sticky unchanged", d, 8'h02);

    // R7 write-zero keeps, write-one clears
    wr(8'h91, 8'h05);
    rd(8'h91, d); chk("R7 zero bit keeps sticky", d, 8'h02);

    // R5 restart by tach pulse
    tach_pulse[1] = 1'b1;
    @(negedge clk);
    tach_pulse[1] = 1'b0;
    rd(8'h92, d); chk("R5 tach pulse clears stall", d, 8'h00);
    wr(8'h91, 8'h02);
    rd(8'h91, d); chk("R7 one bit clears sticky", d, 8'h00);
    chk("R9 pme_n high after clear", {7'd0, pme_n}, 8'h01);

    // R5 restart by zero duty
    repeat (2000) @(negedge clk);
    duty[15:8] = 8'd0;
    @(negedge clk);
    duty[15:8] = 8'd50;
    repeat (2000) @(negedge clk);
    rd(8'h92, d); chk("R5 zero duty restarts stall", d, 8'h00);
    healthy();
    @(negedge clk);

    // R8 set wins over same-cycle clear (fan 3, timeout 3)
    timeout = {3{8'd3}};
    @(negedge clk);
    tach_count[47:32] = 16'd300;
    repeat (4) @(negedge clk);
    rd(8'h92, d); chk("R8 fault present", d, 8'h04);
    wr(8'h91, 8'h04);
    rd(8'h91, d); chk("R8 set beats clear", d, 8'h04);
    healthy();
    @(negedge clk);

    // R2 reserved bits and unmapped index
    wr(8'h90, 8'hFF);
    rd(8'h90, d); chk("R2 reserved enable bits", d, 8'h07);
    rd(8'h93, d); chk("R2 unmapped index", d, 8'h00);
    rd(8'h8F, d); chk("R2 unmapped index low", d, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule